// File: doc/BRIEF.md
# Programmable Sum-of-Products Trigger Logic

The block turns a vector of trigger input bits into a set of trigger decisions each clock cycle. Every decision is a condition: an OR over a small number of terms, where each term is an AND over chosen input bits, each bit taken either as it is or inverted. The terms are held in configuration registers. Each term slot stores a valid flag, a mask that selects which inputs take part, and a mask that selects which of those are inverted.

Configuration is loaded through a one-cycle write strobe that names a condition and a term slot. All decisions are registered, so they appear one clock after the inputs are sampled. A summary flag is also registered and shows that at least one decision fired. The number of decisions produced is the lower of two parameters: the output count and the condition count.

Top module: `trig_sop_unit`

## Requirements
- R1: A condition is true when any of its valid terms is true. A term is true when every input selected by its use mask (bit k of the mask selects trig_i[k]) satisfies its literal.
- R2: A selected input whose invert mask bit is 1 is satisfied when that input is 0. A selected input whose invert mask bit is 0 is satisfied when that input is 1.
- R3: A condition with no valid term is true, whatever the inputs are.
- R4: A valid term with an all-zero use mask is true, so its condition is true.
- R5: A term slot whose valid flag is 0 adds nothing to its condition, whatever its masks hold.
- R6: any_o is 1 exactly when at least one bit of cond_o is 1, in the same cycle.
- R7: cond_o and any_o change one clock edge after trig_i is sampled, and not before.
- R8: A configuration write captured at edge k does not affect the result produced at edge k. It takes effect in the result produced at edge k+1.
- R9: An active reset drives cond_o and any_o to 0 and marks every term slot invalid.
- R10: Only min(OUT_CNT, COND_CNT) conditions are evaluated; cond_o bit c carries condition c. A write to a condition index at or above that count changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | IN_W | Trigger input bits |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_cond_i | input | $clog2(COND_CNT) | Condition index of the write |
| cfg_term_i | input | $clog2(TERM_CNT) | Term slot index of the write |
| cfg_valid_i | input | 1 | Valid flag written to the term slot |
| cfg_use_i | input | IN_W | Input-select mask for the term |
| cfg_inv_i | input | IN_W | Inversion mask for the term |
| cond_o | output | min(OUT_CNT, COND_CNT) | Registered condition results |
| any_o | output | 1 | Registered OR of all condition results |

## Verification
The bench first checks the state right after reset. With no term loaded, every condition must read true. A design that treated an empty condition as false would show zeros here. One valid term with an empty use mask keeps its condition true even when all inputs are set, and invalidating that slot must then let the condition drop. A design that ignored the valid flag would keep the condition stuck at 1. A write is issued in the same cycle as an input change, so a design that applied new masks one edge early shows up. Writes to condition slots beyond the evaluated count must leave every output at 0. A pattern that drives every condition false must also clear the summary flag.

// File: rtl/sop_trig_pkg.sv
package sop_trig_pkg;
  function automatic int min_int(input int a, input int b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/sop_cfg_store.sv
module sop_cfg_store #(
  parameter int IN_W     = 16,
  parameter int EVAL_CNT = 6,
  parameter int TERM_CNT = 4,
  parameter int CW       = 3,
  parameter int TW       = 2,
  localparam int SLOTS   = EVAL_CNT * TERM_CNT
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [CW-1:0]              cond_i,
  input  logic [TW-1:0]              term_i,
  input  logic                       valid_i,
  input  logic [IN_W-1:0]            use_i,
  input  logic [IN_W-1:0]            inv_i,
  output logic [SLOTS-1:0]           valid_o,
  output logic [SLOTS-1:0][IN_W-1:0] use_o,
  output logic [SLOTS-1:0][IN_W-1:0] inv_o
);
  logic [SLOTS-1:0]           valid_q;
  logic [SLOTS-1:0][IN_W-1:0] use_q, inv_q;
  logic                       wr_ok;
  int                         wr_slot;

  // slots above the evaluated range are never stored
  always_comb begin
    wr_ok   = we_i && (int'(cond_i) < EVAL_CNT) && (int'(term_i) < TERM_CNT);
    wr_slot = int'(cond_i) * TERM_CNT + int'(term_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      use_q   <= '0;
      inv_q   <= '0;
    end else if (wr_ok) begin
      for (int s = 0; s < SLOTS; s++) begin
        if (wr_slot == s) begin
          valid_q[s] <= valid_i;
          use_q[s]   <= use_i;
          inv_q[s]   <= inv_i;
        end
      end
    end
  end

  assign valid_o = valid_q;
  assign use_o   = use_q;
  assign inv_o   = inv_q;

  // R8
  cfg_apply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok |=> (valid_q[$past(wr_slot)] == $past(valid_i)) &&
              (use_q[$past(wr_slot)] == $past(use_i)) &&
              (inv_q[$past(wr_slot)] == $past(inv_i)));

  // R9
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      cfg_reset_chk: assert (valid_q == '0);
    end
  end
endmodule

// File: rtl/sop_term.sv
module sop_term #(
  parameter int IN_W = 16
) (
  input  logic [IN_W-1:0] trig_i,
  input  logic            valid_i,
  input  logic [IN_W-1:0] use_i,
  input  logic [IN_W-1:0] inv_i,
  output logic            hit_o
);
  // a literal passes when input differs from its invert bit
  assign hit_o = valid_i & (&(~use_i | (trig_i ^ inv_i)));
endmodule

// File: rtl/sop_cond.sv
module sop_cond #(
  parameter int IN_W     = 16,
  parameter int TERM_CNT = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [IN_W-1:0]               trig_i,
  input  logic [TERM_CNT-1:0]           valid_i,
  input  logic [TERM_CNT-1:0][IN_W-1:0] use_i,
  input  logic [TERM_CNT-1:0][IN_W-1:0] inv_i,
  output logic                          hit_o
);
  logic [TERM_CNT-1:0] term_hit;

  for (genvar t = 0; t < TERM_CNT; t++) begin : g_term
    sop_term #(.IN_W(IN_W)) u_term (
      .trig_i  (trig_i),
      .valid_i (valid_i[t]),
      .use_i   (use_i[t]),
      .inv_i   (inv_i[t]),
      .hit_o   (term_hit[t])
    );

    // R4
    empty_term_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i[t] && use_i[t] == '0) |-> hit_o);
  end

  assign hit_o = ~(|valid_i) | (|term_hit);

  // R3
  empty_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i == '0) |-> hit_o);
endmodule

// File: rtl/trig_sop_unit.sv
module trig_sop_unit
  import sop_trig_pkg::*;
#(
  parameter int IN_W     = 16,
  parameter int OUT_CNT  = 6,
  parameter int COND_CNT = 8,
  parameter int TERM_CNT = 4,
  localparam int EVAL_CNT = min_int(OUT_CNT, COND_CNT),
  localparam int CW = (COND_CNT > 1) ? $clog2(COND_CNT) : 1,
  localparam int TW = (TERM_CNT > 1) ? $clog2(TERM_CNT) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [IN_W-1:0]     trig_i,
  input  logic                cfg_we_i,
  input  logic [CW-1:0]       cfg_cond_i,
  input  logic [TW-1:0]       cfg_term_i,
  input  logic                cfg_valid_i,
  input  logic [IN_W-1:0]     cfg_use_i,
  input  logic [IN_W-1:0]     cfg_inv_i,
  output logic [EVAL_CNT-1:0] cond_o,
  output logic                any_o
);
  localparam int SLOTS = EVAL_CNT * TERM_CNT;

  logic [SLOTS-1:0]           slot_valid;
  logic [SLOTS-1:0][IN_W-1:0] slot_use, slot_inv;
  logic [EVAL_CNT-1:0]        cond_d, cond_q;
  logic                       any_q;

  sop_cfg_store #(
    .IN_W(IN_W), .EVAL_CNT(EVAL_CNT), .TERM_CNT(TERM_CNT), .CW(CW), .TW(TW)
  ) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .cond_i  (cfg_cond_i),
    .term_i  (cfg_term_i),
    .valid_i (cfg_valid_i),
    .use_i   (cfg_use_i),
    .inv_i   (cfg_inv_i),
    .valid_o (slot_valid),
    .use_o   (slot_use),
    .inv_o   (slot_inv)
  );

  for (genvar c = 0; c < EVAL_CNT; c++) begin : g_cond
    sop_cond #(.IN_W(IN_W), .TERM_CNT(TERM_CNT)) u_cond (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .trig_i  (trig_i),
      .valid_i (slot_valid[c*TERM_CNT +: TERM_CNT]),
      .use_i   (slot_use[c*TERM_CNT +: TERM_CNT]),
      .inv_i   (slot_inv[c*TERM_CNT +: TERM_CNT]),
      .hit_o   (cond_d[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cond_q <= '0;
      any_q  <= 1'b0;
    end else begin
      cond_q <= cond_d;
      any_q  <= |cond_d;
    end
  end

  assign cond_o = cond_q;
  assign any_o  = any_q;

  // R6
  any_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_q == (cond_q != '0));

  // R7
  reg_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> cond_q == $past(cond_d));

  // R9
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      out_reset_chk: assert (cond_q == '0 && !any_q);
    end
  end
endmodule

// File: tb/trig_sop_unit_bench.sv
module trig_sop_unit_bench;
  localparam int IN_W = 16;
  localparam int NV   = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] trig = '0;
  logic        we = 1'b0;
  logic [2:0]  cidx = '0;
  logic [1:0]  tidx = '0;
  logic        vld = 1'b0;
  logic [15:0] usem = '0;
  logic [15:0] invm = '0;
  logic [5:0]  cond;
  logic        any;
  int          n_chk = 0;
  int          n_bad = 0;

  always #10 clk = ~clk;

  trig_sop_unit u_trig_sop_unit (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .cfg_we_i(we),
    .cfg_cond_i(cidx), .cfg_term_i(tidx), .cfg_valid_i(vld),
    .cfg_use_i(usem), .cfg_inv_i(invm), .cond_o(cond), .any_o(any)
  );

  // c0=(i0&i1)|!i4, c1=i8, c2 empty, c3=!i15|empty-term, c4=i4&!i5&i6&!i7, c5=i9|!i10
  localparam logic [15:0] VEC_IN  [NV] = '{16'h0000, 16'h0013, 16'h0010, 16'h0450,
                                          16'h0750, 16'h04F0, 16'hFFFF, 16'h0410};
  localparam logic [5:0]  VEC_EXP [NV] = '{6'h2D, 6'h2D, 6'h2C, 6'h1C,
                                          6'h3E, 6'h0C, 6'h2F, 6'h0C};

  task automatic chk(input logic [5:0] ec, input logic ea, input string req);
    n_chk++;
    if (cond !== ec || any !== ea) begin
      n_bad++;
      $display("FAIL %s: cond=%h any=%b expected cond=%h any=%b", req, cond, any, ec, ea);
    end
  endtask

  task automatic cfg_write(input logic [2:0] c, input logic [1:0] t, input logic v,
                           input logic [15:0] u, input logic [15:0] n);
    cidx = c; tidx = t; vld = v; usem = u; invm = n; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic step(input logic [15:0] v);
    trig = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: cond=%h any=%b expected completion", cond, any);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    trig = 16'hFFFF;
    repeat (2) @(negedge clk);
    chk(6'h00, 1'b0, "R9 outputs cleared in reset");
    rst_n = 1'b1;
    step(16'h0000);
    chk(6'h3F, 1'b1, "R3/R9 empty conditions after reset");

    cfg_write(3'd0, 2'd0, 1'b1, 16'h0003, 16'h0000);
    cfg_write(3'd0, 2'd1, 1'b1, 16'h0010, 16'h0010);
    cfg_write(3'd1, 2'd0, 1'b1, 16'h0100, 16'h0000);
    cfg_write(3'd3, 2'd0, 1'b1, 16'h8000, 16'h8000);
    cfg_write(3'd3, 2'd2, 1'b1, 16'h0000, 16'h0000);
    cfg_write(3'd4, 2'd0, 1'b1, 16'h00F0, 16'h00A0);
    cfg_write(3'd5, 2'd1, 1'b1, 16'h0200, 16'h0000);
    cfg_write(3'd5, 2'd3, 1'b1, 16'h0400, 16'h0400);

    // R1 R2 R4 R6 over the vector table
    for (int i = 0; i < NV; i++) begin
      step(VEC_IN[i]);
      chk(VEC_EXP[i], 1'b1, $sformatf("R1/R2/R4 vector %0d", i));
    end

    // R7: no change before the edge
    trig = 16'h0750;
    #2;
    chk(6'h0C, 1'b1, "R7 before edge");
    @(negedge clk);
    chk(6'h3E, 1'b1, "R7 after edge");

    // R8: write in the same cycle as the input change
    trig = 16'h8000;
    cidx = 3'd2; tidx = 2'd0; vld = 1'b1; usem = 16'h8000; invm = 16'h8000; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    chk(6'h2D, 1'b1, "R8 old config at write edge");
    @(negedge clk);
    chk(6'h29, 1'b1, "R8 new config next edge");

    // R5: invalidate the empty term of c3
    cfg_write(3'd2, 2'd0, 1'b1, 16'h8000, 16'h0000);
    cfg_write(3'd3, 2'd2, 1'b0, 16'h0000, 16'h0000);
    cfg_write(3'd3, 2'd0, 1'b1, 16'h8000, 16'h0000);
    step(16'h0410);
    chk(6'h00, 1'b0, "R5/R6 invalid slot, all false");
    step(16'h8410);
    chk(6'h0C, 1'b1, "R5/R6 i15 set");

    // R10: writes beyond evaluated range
    cfg_write(3'd6, 2'd0, 1'b1, 16'h0000, 16'h0000);
    cfg_write(3'd7, 2'd1, 1'b1, 16'h0000, 16'h0000);
    step(16'h0410);
    chk(6'h00, 1'b0, "R10 high condition writes ignored");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule